// File: doc/BRIEF.md
# Fracturable Lookup-Table Logic Element

This block is one logic element of a programmable fabric. At its core is a 256-entry table of single bits, addressed by eight logic inputs, so it can produce any Boolean function of those eight inputs. The same table can instead act as two independent 128-entry tables, each addressed by seven inputs, giving two separate functions from one element. Both table outputs pass through output multiplexers that choose between the raw combinational value and a flip-flop copy of it.

The element holds four flip-flops. Each one loads either a table output or a direct link signal from the neighbouring element, under a shared clock enable and a shared synchronous clear. The element also drives the upper table output, unregistered, to its neighbour, so elements can be cascaded into fast chains. Table contents and the mode byte are loaded one byte per cycle through a small write port. Outputs are not meaningful while the element is being reconfigured.

Top module: `lut_logic_element`

## Requirements
- R1: A write with `cfg_we` high and `cfg_addr` k in 0..31 stores `cfg_data` bit j into table entry 8k+j at that clock edge. The outputs show the new contents from the following cycle, and not before that edge.
- R2: A write to `cfg_addr` 32 loads the mode byte. Bit 0 selects split mode. Bit 1 registers `y_lo`. Bit 2 registers `y_hi`. Bits 3..6 select the link input as the data source of flip-flops 0..3. Writes to addresses 33..63 change neither the table nor the mode.
- R3: In unsplit mode, `y_lo` and `y_hi` both equal table entry `lut_in` when they are combinational.
- R4: With table byte 0 = 0xC2, all other entries 0, and `lut_in[7:3]` = 0, the element gives y = a·b + a'·b'·c for all 8 combinations, where a = `lut_in[2]`, b = `lut_in[1]` and c = `lut_in[0]`.
- R5: In split mode, `y_lo` equals entry `lut_in[6:0]` (entries 0..127). `y_hi` equals entry 128 + {`lut_in[7]`, `lut_in[5:0]`}.
- R6: `chain_out` always carries the unregistered upper table output, which is the `y_hi` value of R3 or R5.
- R7: When its mode bit is set, `y_lo` shows flip-flop 0 and `y_hi` shows flip-flop 1. Each then takes the value its table output had at the previous clock edge.
- R8: Flip-flops 0 and 2 load the lower table output, and flip-flops 1 and 3 load the upper one, unless their mode bit selects `chain_in`. `ff_aux[0]` shows flip-flop 2 and `ff_aux[1]` shows flip-flop 3.
- R9: With `ff_ce` low, all flip-flops hold their value. `ff_sclr` high clears all of them at the next edge, whatever `ff_ce` is.
- R10: After reset the table, the mode and all flip-flops are 0, so every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address (0..31 table, 32 mode) |
| cfg_data | input | 8 | Configuration write byte |
| lut_in | input | 8 | Logic inputs addressing the table |
| ff_ce | input | 1 | Clock enable for all flip-flops |
| ff_sclr | input | 1 | Synchronous clear for all flip-flops |
| chain_in | input | 1 | Direct link from the neighbouring element |
| y_lo | output | 1 | Lower output, combinational or registered |
| y_hi | output | 1 | Upper output, combinational or registered |
| ff_aux | output | 2 | Flip-flops 2 and 3 |
| chain_out | output | 1 | Unregistered upper table output to the neighbour |

## Verification
On every cycle, the assertions check the flip-flop rules: clear, hold while disabled, and loading from the link input. They also check that a registered output tracks its flip-flop, that a combinational upper output matches `chain_out`, and that the two outputs agree in unsplit mode. Only the bench scenarios can show that table contents map to the right outputs. These cover the three-input example function, the split addressing with its shared inputs, the one-cycle visibility of configuration writes, and the fact that out-of-range writes have no effect.

// File: rtl/lle_pkg.sv
package lle_pkg;

    localparam int NUM_FF = 4;

    // mode byte, bit 0 at the bottom
    typedef struct packed {
        logic              spare;
        logic [NUM_FF-1:0] ff_chain;
        logic              reg_hi;
        logic              reg_lo;
        logic              split;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/lle_cfg_store.sv
module lle_cfg_store
    import lle_pkg::*;
#(
    parameter int LUT_INPUTS = 8,
    parameter int CFG_W      = 8,
    localparam int TABLE_BITS = 1 << LUT_INPUTS,
    localparam int NUM_WORDS  = TABLE_BITS / CFG_W,
    localparam int ADDR_W     = $clog2(NUM_WORDS) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [CFG_W-1:0]      cfg_data,
    output logic [TABLE_BITS-1:0] tbl,
    output mode_t                 mode
);

    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_WORDS);

    typedef struct packed {
        logic [TABLE_BITS-1:0] tbl;
        mode_t                 mode;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (cfg_addr == ADDR_W'(w)) begin
                    st_d.tbl[w*CFG_W +: CFG_W] = cfg_data;
                end
            end
            if (cfg_addr == MODE_ADDR) begin
                st_d.mode = mode_t'(cfg_data[MODE_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tbl  = st_q.tbl;
    assign mode = st_q.mode;

endmodule

// File: rtl/lle_lut_read.sv
module lle_lut_read #(
    parameter int LUT_INPUTS = 8,
    localparam int TABLE_BITS = 1 << LUT_INPUTS,
    localparam int HALF_BITS  = TABLE_BITS / 2,
    localparam int HALF_IN    = LUT_INPUTS - 1
) (
    input  logic [TABLE_BITS-1:0] tbl,
    input  logic                  split,
    input  logic [LUT_INPUTS-1:0] lut_in,
    output logic                  lut_lo,
    output logic                  lut_hi
);

    logic [HALF_BITS-1:0] half_lo, half_hi;
    logic [HALF_IN-1:0]   idx_lo, idx_hi;
    logic                 full_val, lo_val, hi_val;

    assign half_lo = tbl[HALF_BITS-1:0];
    assign half_hi = tbl[TABLE_BITS-1:HALF_BITS];

    // lower half uses the low inputs; upper half swaps the next-to-top
    // input for the top one, sharing the rest
    assign idx_lo = lut_in[HALF_IN-1:0];
    assign idx_hi = {lut_in[LUT_INPUTS-1], lut_in[HALF_IN-2:0]};

    always_comb begin
        full_val = tbl[lut_in];
        lo_val   = half_lo[idx_lo];
        hi_val   = half_hi[idx_hi];
        lut_lo   = split ? lo_val : full_val;
        lut_hi   = split ? hi_val : full_val;
    end

endmodule

// File: rtl/lle_ff_bank.sv
module lle_ff_bank #(
    parameter int NUM_FF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              sclr,
    input  logic              lut_lo,
    input  logic              lut_hi,
    input  logic              chain_in,
    input  logic [NUM_FF-1:0] chain_sel,
    output logic [NUM_FF-1:0] ff_q
);

    typedef struct packed {
        logic [NUM_FF-1:0] bits;
    } ff_state_t;

    ff_state_t         st_d, st_q;
    logic [NUM_FF-1:0] din;

    for (genvar i = 0; i < NUM_FF; i++) begin : g_src
        if (i % 2 == 0) begin : g_even
            assign din[i] = chain_sel[i] ? chain_in : lut_lo;
        end else begin : g_odd
            assign din[i] = chain_sel[i] ? chain_in : lut_hi;
        end
    end

    always_comb begin
        st_d = st_q;
        if (sclr) begin
            st_d.bits = '0;
        end else if (ce) begin
            st_d.bits = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ff_q = st_q.bits;

endmodule

// File: rtl/lut_logic_element.sv
module lut_logic_element
    import lle_pkg::*;
#(
    parameter int LUT_INPUTS = 8,
    parameter int CFG_W      = 8,
    localparam int TABLE_BITS = 1 << LUT_INPUTS,
    localparam int NUM_WORDS  = TABLE_BITS / CFG_W,
    localparam int ADDR_W     = $clog2(NUM_WORDS) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [CFG_W-1:0]      cfg_data,
    input  logic [LUT_INPUTS-1:0] lut_in,
    input  logic                  ff_ce,
    input  logic                  ff_sclr,
    input  logic                  chain_in,
    output logic                  y_lo,
    output logic                  y_hi,
    output logic [NUM_FF-3:0]     ff_aux,
    output logic                  chain_out
);

    logic [TABLE_BITS-1:0] tbl;
    mode_t                 mode_q;
    logic                  lut_lo, lut_hi;
    logic [NUM_FF-1:0]     ff_q;

    lle_cfg_store #(.LUT_INPUTS(LUT_INPUTS), .CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .tbl      (tbl),
        .mode     (mode_q)
    );

    lle_lut_read #(.LUT_INPUTS(LUT_INPUTS)) u_lut (
        .tbl    (tbl),
        .split  (mode_q.split),
        .lut_in (lut_in),
        .lut_lo (lut_lo),
        .lut_hi (lut_hi)
    );

    lle_ff_bank #(.NUM_FF(NUM_FF)) u_ff (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ff_ce),
        .sclr      (ff_sclr),
        .lut_lo    (lut_lo),
        .lut_hi    (lut_hi),
        .chain_in  (chain_in),
        .chain_sel (mode_q.ff_chain),
        .ff_q      (ff_q)
    );

    assign y_lo      = mode_q.reg_lo ? ff_q[0] : lut_lo;
    assign y_hi      = mode_q.reg_hi ? ff_q[1] : lut_hi;
    assign ff_aux    = ff_q[NUM_FF-1:2];
    assign chain_out = lut_hi;

endmodule

// File: rtl/lle_checker.sv
module lle_checker
    import lle_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ff_ce,
    input logic              ff_sclr,
    input logic              chain_in,
    input logic              chain_out,
    input logic              y_lo,
    input logic              y_hi,
    input mode_t             mode_q,
    input logic [NUM_FF-1:0] ff_q
);

    p_ff_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ff_sclr |=> (ff_q == '0));

    p_ff_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ff_ce && !ff_sclr) |=> $stable(ff_q));

    p_chain_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ff_ce && !ff_sclr && mode_q.ff_chain[2]) |=> (ff_q[2] == $past(chain_in)));

    p_reg_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.reg_lo |-> (y_lo == ff_q[0]));

    p_comb_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q.reg_hi |-> (y_hi == chain_out));

    p_full_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q.split && !mode_q.reg_lo && !mode_q.reg_hi) |-> (y_lo == y_hi));

endmodule

bind lut_logic_element lle_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ff_ce     (ff_ce),
    .ff_sclr   (ff_sclr),
    .chain_in  (chain_in),
    .chain_out (chain_out),
    .y_lo      (y_lo),
    .y_hi      (y_hi),
    .mode_q    (mode_q),
    .ff_q      (ff_q)
);

// File: tb/sim_lut_logic_element.sv
module sim_lut_logic_element;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic [7:0] cfg_data = '0;
    logic [7:0] lut_in = '0;
    logic       ff_ce = 1'b0;
    logic       ff_sclr = 1'b0;
    logic       chain_in = 1'b0;
    logic       y_lo, y_hi, chain_out;
    logic [1:0] ff_aux;

    int   n_checks = 0;
    int   n_errors = 0;
    logic [255:0] mdl = '0;

    // {a,b,c, expected y} for y = ab + a'b'c
    localparam logic [3:0] R4_VEC [8] = '{
        {3'b000, 1'b0}, {3'b001, 1'b1}, {3'b010, 1'b0}, {3'b011, 1'b0},
        {3'b100, 1'b0}, {3'b101, 1'b0}, {3'b110, 1'b1}, {3'b111, 1'b1}
    };

    always #5 clk = ~clk;

    lut_logic_element u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .lut_in(lut_in), .ff_ce(ff_ce), .ff_sclr(ff_sclr),
        .chain_in(chain_in), .y_lo(y_lo), .y_hi(y_hi), .ff_aux(ff_aux),
        .chain_out(chain_out)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 6'd32) mdl[a*8 +: 8] = d;
    endtask

    function automatic logic exp_lo(input logic [7:0] v, input logic sp);
        return sp ? mdl[{1'b0, v[6:0]}] : mdl[v];
    endfunction

    function automatic logic exp_hi(input logic [7:0] v, input logic sp);
        return sp ? mdl[{1'b1, v[7], v[5:0]}] : mdl[v];
    endfunction

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset y_lo", y_lo, 1'b0);
        chk("R10 reset y_hi", y_hi, 1'b0);
        chk("R10 reset aux", |ff_aux, 1'b0);
        chk("R10 reset chain_out", chain_out, 1'b0);
        rst_n = 1'b1;

        // R4: three-input example function in table byte 0
        cfg_write(6'd0, 8'hC2);
        for (int i = 0; i < 8; i++) begin
            lut_in = {5'b0, R4_VEC[i][3:1]};
            #1;
            chk("R4 y_lo", y_lo, R4_VEC[i][0]);
            chk("R4 y_hi", y_hi, R4_VEC[i][0]);
        end

        // R1: write takes effect only after its clock edge
        lut_in = 8'd0;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'd0; cfg_data = 8'hFF;
        #1;
        chk("R1 before edge", y_lo, 1'b0);
        @(negedge clk);
        cfg_we = 1'b0; mdl[7:0] = 8'hFF;
        #1;
        chk("R1 after edge", y_lo, 1'b1);

        // R1: program full pattern
        for (int k = 0; k < 32; k++) cfg_write(6'(k), 8'(k * 37 + 101));

        // R3, R6: unsplit mode
        for (int v = 0; v < 256; v += 13) begin
            lut_in = 8'(v);
            #1;
            chk("R3 y_lo", y_lo, exp_lo(8'(v), 1'b0));
            chk("R3 y_hi", y_hi, exp_hi(8'(v), 1'b0));
            chk("R6 chain_out", chain_out, exp_hi(8'(v), 1'b0));
        end

        // R5, R6: split mode
        cfg_write(6'd32, 8'h01);
        for (int v = 0; v < 256; v += 11) begin
            lut_in = 8'(v);
            #1;
            chk("R5 y_lo", y_lo, exp_lo(8'(v), 1'b1));
            chk("R5 y_hi", y_hi, exp_hi(8'(v), 1'b1));
            chk("R6 chain_out split", chain_out, exp_hi(8'(v), 1'b1));
        end

        // R2: writes above the mode address are ignored
        cfg_write(6'd40, 8'hFF);
        cfg_write(6'd63, 8'h00);
        for (int v = 3; v < 256; v += 29) begin
            lut_in = 8'(v);
            #1;
            chk("R2 ignored y_lo", y_lo, exp_lo(8'(v), 1'b1));
            chk("R2 ignored y_hi", y_hi, exp_hi(8'(v), 1'b1));
        end

        // R7, R8: registered outputs, table sources for all flip-flops
        ff_ce = 1'b1;
        cfg_write(6'd32, 8'h07);
        for (int v = 5; v < 256; v += 31) begin
            lut_in = 8'(v);
            @(negedge clk);
            #1;
            chk("R7 y_lo reg", y_lo, exp_lo(8'(v), 1'b1));
            chk("R7 y_hi reg", y_hi, exp_hi(8'(v), 1'b1));
            chk("R8 aux0 lo src", ff_aux[0], exp_lo(8'(v), 1'b1));
            chk("R8 aux1 hi src", ff_aux[1], exp_hi(8'(v), 1'b1));
        end

        // R8: link source on flip-flops 0 and 2
        cfg_write(6'd32, 8'h2F);
        chain_in = 1'b1;
        @(negedge clk); #1;
        chk("R8 aux0 chain 1", ff_aux[0], 1'b1);
        chk("R8 y_lo chain 1", y_lo, 1'b1);
        chain_in = 1'b0;
        @(negedge clk); #1;
        chk("R8 aux0 chain 0", ff_aux[0], 1'b0);
        chk("R8 y_lo chain 0", y_lo, 1'b0);
        chain_in = 1'b1;
        @(negedge clk); #1;

        // R9: hold with enable low, then clear with enable low
        ff_ce = 1'b0;
        chain_in = 1'b0;
        @(negedge clk); #1;
        chk("R9 hold aux0", ff_aux[0], 1'b1);
        chk("R9 hold y_lo", y_lo, 1'b1);
        ff_sclr = 1'b1;
        @(negedge clk); #1;
        ff_sclr = 1'b0;
        chk("R9 clear aux", |ff_aux, 1'b0);
        chk("R9 clear y_lo", y_lo, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule